// File: doc/BRIEF.md
# SD Card SPI-Mode Start-Up Sequencer

This block takes a freshly powered SD card from its native state into SPI mode and walks it through the first identification exchange. It acts as the SPI controller. It derives a slow serial clock from the system clock and sends a run of wake-up clocks with chip select released. It then issues three commands in a fixed order. Each command goes out as a 48-bit frame whose CRC7 the block computes itself.

After each frame the block polls for the one-byte R1 reply. While the card reports that it is still idle, the block repeats the capacity-announcing initialisation command. After the final command it reads the four trailing bytes and checks the echoed pattern. The block finishes with a sticky done flag or a sticky error flag. The error flag comes with a two-bit cause code. The most recent R1 byte is always visible on an output port.

The block starts on its own when reset is released, so no start pulse is needed. It is meant to sit in front of a data-transfer engine. That engine takes over the card once `init_done` rises.

Top module: `sd_spi_boot`

## Requirements
- R1: While reset is asserted and just after it is released, `spi_sclk` is 0, `spi_cs_n` is 1, `spi_mosi` is 1, `init_done` and `init_err` are 0, and `r1_last` reads 8'hFF.
- R2: Every `spi_sclk` level lasts exactly DIV_HALF system clock cycles. The default of 157 gives about 398 kHz from a 125 MHz clock. `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is sampled on the rising edge.
- R3: Before the first command, exactly WAKE_CLKS rising edges (default 80, at least 74) occur with `spi_cs_n` high and `spi_mosi` 1. `spi_cs_n` falls at the start of the first frame, so the first bit clocked with chip select low is that frame's start bit.
- R4: A frame is 48 bits sent MSB first, in this order: 0, 1, a 6-bit command index, a 32-bit argument, a 7-bit CRC and a final 1. The CRC uses x^7+x^3+1 with a zero start value over the first 40 bits, so the last byte of the reset command is 8'h95.
- R5: The commands go out in this order: index 0 with argument 0, then index 1 with argument 32'h4000_0000, then index 8 with argument 32'h0000_01A5.
- R6: After a frame, `spi_mosi` stays at 1 and replies are read in whole bytes. The first byte whose bit 7 is 0 is taken as R1 and copied to `r1_last`. If none of the first RESP_BYTES bytes (default 8) qualifies, `init_err` rises with `err_code` = 1.
- R7: Index 1 is re-sent while R1 bit 0 is 1. At most MAX_RETRY index-1 frames are sent. If the last of them is still answered with bit 0 set, `init_err` rises with `err_code` = 2 and index 8 is never sent.
- R8: After the R1 of index 8, four more bytes are read. If the fourth byte is not 8'hA5, `init_err` rises with `err_code` = 3.
- R9: Exactly GAP_CLKS rising edges (default 8) occur with `spi_cs_n` high between consecutive frames, and again after the last trailer byte before `init_done` rises.
- R10: `init_done` and `init_err` hold until reset. Once either is set, `spi_sclk` stays low and `spi_cs_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | output | 1 | Serial clock to the card, idle low |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |
| init_done | output | 1 | Start-up completed successfully |
| init_err | output | 1 | Start-up aborted |
| err_code | output | 2 | Cause of the abort: 1 = no reply, 2 = retries used up, 3 = bad echo |
| r1_last | output | 8 | Most recent R1 byte received |

## Verification
Two decisions can land on the same bit-end event. At the last permitted poll byte, accepting a reply competes with declaring a timeout. On the final allowed retry, an idle reply competes with the retry cap. The card model places R1 in the 8th byte and then in the 9th, and it leaves idle on exactly the last allowed attempt and then never. In each case the bench judges the outcome from the logged command stream, `err_code` and `init_done`.

// File: rtl/sd_spi_boot.sv
`timescale 1ns/1ps
module sd_spi_boot #(
  parameter int DIV_HALF   = 157,
  parameter int WAKE_CLKS  = 80,
  parameter int GAP_CLKS   = 8,
  parameter int RESP_BYTES = 8,
  parameter int MAX_RETRY  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       init_done,
  output logic       init_err,
  output logic [1:0] err_code,
  output logic [7:0] r1_last
);
  localparam int DW   = $clog2(DIV_HALF + 1);
  localparam int BM0  = (WAKE_CLKS > 48) ? WAKE_CLKS : 48;
  localparam int BMAX = (GAP_CLKS > BM0) ? GAP_CLKS : BM0;
  localparam int BW   = $clog2(BMAX + 1);
  localparam int NW   = $clog2(RESP_BYTES + 1);
  localparam int RW   = $clog2(MAX_RETRY + 1);

  typedef enum logic [2:0] {ST_WAKE, ST_SEND, ST_POLL, ST_TRAIL, ST_GAP, ST_DONE, ST_FAIL} st_t;

  st_t          st;
  logic [DW-1:0] dcnt;
  logic          sck;
  logic [BW-1:0] bcnt;
  logic [NW-1:0] nby;
  logic [RW-1:0] tries;
  logic [1:0]    sel;
  logic [47:0]   tx;
  logic [7:0]    rx;
  logic [5:0]    idx;
  logic [31:0]   arg;
  logic [39:0]   head;
  logic [47:0]   frame;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = c[6] ^ d[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  always_comb begin
    case (sel)
      2'd1:    begin idx = 6'd1; arg = 32'h4000_0000; end
      2'd2:    begin idx = 6'd8; arg = 32'h0000_01A5; end
      default: begin idx = 6'd0; arg = 32'h0000_0000; end
    endcase
  end

  assign head  = {2'b01, idx, arg};
  assign frame = {head, crc7(head), 1'b1};

  logic run, tick, rise, fall;
  assign run  = (st != ST_DONE) && (st != ST_FAIL);
  assign tick = run && (dcnt == DW'(DIV_HALF - 1));
  assign rise = tick && !sck;
  assign fall = tick && sck;

  assign spi_sclk  = sck;
  assign spi_cs_n  = !((st == ST_SEND) || (st == ST_POLL) || (st == ST_TRAIL));
  assign spi_mosi  = (st == ST_SEND) ? tx[47] : 1'b1;
  assign init_done = (st == ST_DONE);
  assign init_err  = (st == ST_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_WAKE;
      dcnt     <= '0;
      sck      <= 1'b0;
      bcnt     <= '0;
      nby      <= '0;
      tries    <= '0;
      sel      <= 2'd0;
      tx       <= '1;
      rx       <= '1;
      err_code <= 2'd0;
      r1_last  <= 8'hFF;
    end else begin
      if (run) begin
        if (tick) begin
          dcnt <= '0;
          sck  <= ~sck;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
      if (rise) rx <= {rx[6:0], spi_miso};
      if (fall) begin
        bcnt <= bcnt + 1'b1;
        case (st)
          ST_WAKE: if (bcnt == BW'(WAKE_CLKS - 1)) begin
            st   <= ST_SEND;
            bcnt <= '0;
            tx   <= frame;
          end
          ST_SEND: begin
            tx <= {tx[46:0], 1'b1};
            if (bcnt == BW'(47)) begin
              st   <= ST_POLL;
              bcnt <= '0;
              nby  <= '0;
            end
          end
          ST_POLL: if (bcnt == BW'(7)) begin
            bcnt <= '0;
            if (!rx[7]) begin
              r1_last <= rx;
              case (sel)
                2'd0: begin
                  sel <= 2'd1;
                  st  <= ST_GAP;
                end
                2'd1: begin
                  if (!rx[0]) begin
                    sel <= 2'd2;
                    st  <= ST_GAP;
                  end else if (tries == RW'(MAX_RETRY)) begin
                    st       <= ST_FAIL;
                    err_code <= 2'd2;
                  end else begin
                    st <= ST_GAP;
                  end
                end
                default: st <= ST_TRAIL;
              endcase
            end else if (nby == NW'(RESP_BYTES - 1)) begin
              st       <= ST_FAIL;
              err_code <= 2'd1;
            end else begin
              nby <= nby + 1'b1;
            end
          end
          ST_TRAIL: if (bcnt == BW'(31)) begin
            bcnt <= '0;
            if (rx == 8'hA5) begin
              sel <= 2'd3;
              st  <= ST_GAP;
            end else begin
              st       <= ST_FAIL;
              err_code <= 2'd3;
            end
          end
          ST_GAP: if (bcnt == BW'(GAP_CLKS - 1)) begin
            bcnt <= '0;
            if (sel == 2'd3) begin
              st <= ST_DONE;
            end else begin
              st <= ST_SEND;
              tx <= frame;
              if (sel == 2'd1) tries <= tries + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sclk) |-> $past(dcnt) == DW'(DIV_HALF - 1)); // R2
  AST_MOSI_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> !spi_sclk); // R2
  AST_CS_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_mosi); // R3
  AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= RW'(MAX_RETRY)); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |-> err_code != 2'd0); // R6
  AST_QUIET_END: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done || init_err) |=> ($stable(spi_sclk) && spi_cs_n)); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R10
endmodule

// File: tb/sd_spi_boot_bench.sv
`timescale 1ns/1ps
module sd_spi_boot_bench;
  localparam int DIV   = 3;
  localparam int WAKE  = 80;
  localparam int GAP   = 8;
  localparam int NRESP = 8;
  localparam int RETRY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic miso_r = 1'b1;
  logic init_done, init_err;
  logic [1:0] err_code;
  logic [7:0] r1_last;

  always #4 clk = ~clk;

  sd_spi_boot #(.DIV_HALF(DIV), .WAKE_CLKS(WAKE), .GAP_CLKS(GAP),
                .RESP_BYTES(NRESP), .MAX_RETRY(RETRY)) u_sd_spi_boot (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(miso_r), .init_done(init_done),
    .init_err(init_err), .err_code(err_code), .r1_last(r1_last));

  int n_chk = 0;
  int n_bad = 0;

  // card model configuration
  int         cfg_ncr;
  int         cfg_idle;
  logic [7:0] cfg_echo;
  logic [7:0] cfg_r8;

  // card model state and log
  logic [47:0]  fr;
  int           fcnt, n1, ncmd, nb, rises;
  logic [127:0] resp;
  logic [7:0]   rb [16];
  int           log_idx [16];
  logic [31:0]  log_arg [16];
  logic [7:0]   log_lo  [16];
  logic         log_ok  [16];
  int           wake, gap_run, ngap;
  logic         seen, first_ok, wake_bad, gap_bad;

  function automatic logic [6:0] crc_ref(input logic [39:0] d);
    logic [46:0] r;
    r = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  always @(posedge spi_sclk or negedge spi_sclk or negedge rst_n) begin
    if (!rst_n) begin
      fr = '0; fcnt = 0; n1 = 0; ncmd = 0; nb = 0; rises = 0;
      resp = '1; miso_r = 1'b1;
      wake = 0; gap_run = 0; ngap = 0;
      seen = 1'b0; first_ok = 1'b0; wake_bad = 1'b0; gap_bad = 1'b0;
    end else if (spi_sclk) begin
      rises++;
      if (spi_cs_n) begin
        fcnt = 0;
        if (!seen) begin
          wake++;
          if (!spi_mosi) wake_bad = 1'b1;
        end else begin
          gap_run++;
        end
      end else begin
        if (!seen) begin
          seen = 1'b1;
          first_ok = !spi_mosi;
        end
        if (gap_run != 0) begin
          ngap++;
          if (gap_run != GAP) gap_bad = 1'b1;
          gap_run = 0;
        end
        if (fcnt != 0 || !spi_mosi) begin
          fr = {fr[46:0], spi_mosi};
          fcnt++;
          if (fcnt == 48) begin
            fcnt = 0;
            if (ncmd < 16) begin
              log_idx[ncmd] = int'(fr[45:40]);
              log_arg[ncmd] = fr[39:8];
              log_lo[ncmd]  = fr[7:0];
              log_ok[ncmd]  = fr[46] && fr[0] && (fr[7:1] == crc_ref(fr[47:8]));
            end
            ncmd++;
            nb = 0;
            for (int k = 0; k < cfg_ncr; k++) begin rb[nb] = 8'hFF; nb++; end
            case (fr[45:40])
              6'd0: begin rb[nb] = 8'h01; nb++; end
              6'd1: begin rb[nb] = (n1 < cfg_idle) ? 8'h01 : 8'h00; nb++; n1++; end
              6'd8: begin
                rb[nb] = cfg_r8;   nb++;
                rb[nb] = 8'h00;    nb++;
                rb[nb] = 8'h00;    nb++;
                rb[nb] = 8'h01;    nb++;
                rb[nb] = cfg_echo; nb++;
              end
              default: ;
            endcase
            resp = '1;
            for (int k = 0; k < 16; k++)
              if (k < nb) resp[127 - 8*k -: 8] = rb[k];
          end
        end
      end
    end else begin
      miso_r = resp[127];
      resp = {resp[126:0], 1'b1};
    end
  end

  // sclk level-length monitor
  int   hp_cnt, hp_n;
  logic hp_bad, prev_sclk;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_cnt = 0; hp_n = 0; hp_bad = 1'b0; prev_sclk = 1'b0;
    end else begin
      hp_cnt++;
      if (spi_sclk != prev_sclk) begin
        if (hp_n > 0 && hp_cnt != DIV) hp_bad = 1'b1;
        hp_n++;
        hp_cnt = 0;
        prev_sclk = spi_sclk;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic boot(input int ncr, input int idle, input logic [7:0] echo, input logic [7:0] r8);
    int c;
    cfg_ncr = ncr; cfg_idle = idle; cfg_echo = echo; cfg_r8 = r8;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    c = 0;
    while (!(init_done || init_err) && c < 60000) begin
      @(negedge clk);
      c++;
    end
    chk("watchdog: run did not finish", (c < 60000) ? 32'd1 : 32'd0, 32'd1);
  endtask

  task automatic t_reset;
    cfg_ncr = 1; cfg_idle = 0; cfg_echo = 8'hA5; cfg_r8 = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sclk in reset", {31'd0, spi_sclk}, 32'd0);
    chk("R1 cs_n in reset", {31'd0, spi_cs_n}, 32'd1);
    chk("R1 mosi in reset", {31'd0, spi_mosi}, 32'd1);
    chk("R1 done/err in reset", {30'd0, init_done, init_err}, 32'd0);
    chk("R1 r1_last in reset", {24'd0, r1_last}, 32'hFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cs_n after release", {31'd0, spi_cs_n}, 32'd1);
  endtask

  task automatic t_nominal;
    int r0;
    int exp_idx [5] = '{0, 1, 1, 1, 8};
    logic [31:0] exp_arg [5] = '{32'h0, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h1A5};
    boot(1, 2, 8'hA5, 8'h00);
    chk("R10 done after success", {31'd0, init_done}, 32'd1);
    chk("R10 no error on success", {30'd0, err_code}, 32'd0);
    chk("R7 frames with two idle replies", ncmd, 32'd5);
    for (int i = 0; i < 5; i++) begin
      chk($sformatf("R5 index of frame %0d", i), log_idx[i], exp_idx[i]);
      chk($sformatf("R5 argument of frame %0d", i), log_arg[i], exp_arg[i]);
      chk($sformatf("R4 framing/crc of frame %0d", i), {31'd0, log_ok[i]}, 32'd1);
    end
    chk("R4 reset command last byte", {24'd0, log_lo[0]}, 32'h95);
    chk("R3 wake clocks", wake, WAKE);
    chk("R3 mosi high during wake", {31'd0, wake_bad}, 32'd0);
    chk("R3 first bit under cs is start bit", {31'd0, first_ok}, 32'd1);
    chk("R9 gaps between frames", ngap, 32'd4);
    chk("R9 gap length", {31'd0, gap_bad}, 32'd0);
    chk("R9 trailing gap before done", gap_run, GAP);
    chk("R2 sclk level length", {31'd0, hp_bad}, 32'd0);
    chk("R6 r1_last holds index-8 reply", {24'd0, r1_last}, 32'h00);
    r0 = rises;
    repeat (40) @(negedge clk);
    chk("R10 sclk stopped after done", rises, r0);
    chk("R10 cs_n high after done", {31'd0, spi_cs_n}, 32'd1);
    chk("R10 done held", {31'd0, init_done}, 32'd1);
  endtask

  task automatic t_ncr_edge;
    boot(NRESP - 1, 0, 8'hA5, 8'h00);
    chk("R6 reply in last allowed byte accepted", {31'd0, init_done}, 32'd1);
    chk("R6 frames with late replies", ncmd, 32'd3);
  endtask

  task automatic t_timeout;
    boot(NRESP, 0, 8'hA5, 8'h00);
    chk("R6 timeout raises error", {31'd0, init_err}, 32'd1);
    chk("R6 timeout code", {30'd0, err_code}, 32'd1);
    chk("R6 stop after first frame", ncmd, 32'd1);
    chk("R6 r1_last untouched on timeout", {24'd0, r1_last}, 32'hFF);
  endtask

  task automatic t_retry_exhaust;
    int r0;
    boot(0, 100, 8'hA5, 8'h00);
    chk("R7 error when card stays idle", {31'd0, init_err}, 32'd1);
    chk("R7 retry code", {30'd0, err_code}, 32'd2);
    chk("R7 frame count", ncmd, 32'd1 + RETRY);
    chk("R7 index 8 never sent", log_idx[RETRY], 32'd1);
    chk("R6 r1_last idle", {24'd0, r1_last}, 32'h01);
    r0 = rises;
    repeat (40) @(negedge clk);
    chk("R10 sclk stopped after error", rises, r0);
    chk("R10 done stays low", {31'd0, init_done}, 32'd0);
  endtask

  task automatic t_retry_edge;
    boot(0, RETRY - 1, 8'hA5, 8'h00);
    chk("R7 leaving idle on last attempt", {31'd0, init_done}, 32'd1);
    chk("R7 frame count at limit", ncmd, 32'd2 + RETRY);
    chk("R5 final frame is index 8", log_idx[RETRY + 1], 32'd8);
  endtask

  task automatic t_bad_echo;
    boot(2, 0, 8'h5A, 8'h01);
    chk("R8 bad echo raises error", {31'd0, init_err}, 32'd1);
    chk("R8 echo code", {30'd0, err_code}, 32'd3);
    chk("R8 done stays low", {31'd0, init_done}, 32'd0);
    chk("R8 frames sent", ncmd, 32'd3);
    chk("R6 r1_last from index 8", {24'd0, r1_last}, 32'h01);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: global time limit reached");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_nominal();
    t_ncr_edge();
    t_timeout();
    t_retry_exhaust();
    t_retry_edge();
    t_bad_echo();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule